// File: doc/BRIEF.md
# Four-Channel Match Timer

The block holds four independent 32-bit counters behind a small register bus. All four counters share one prescaler. Each counter has its own enable, a synchronous hold-at-zero bit, a count direction and a count-mode field that gates counting. Each counter also has one match value, compared on every count step. A match can raise a sticky interrupt flag, restart the counter from zero, stop the counter, or any mix of the three. One level interrupt output is high while any flag is pending.

Software reaches every register through four word aliases, selected by address bits [3:2]:

| Alias | Offset | Effect of a write |
|---|---|---|
| 0 | +0x0 | Plain write |
| 1 | +0x4 | Sets the written bits |
| 2 | +0x8 | Clears the written bits |
| 3 | +0xC | Toggles the written bits |

This lets a driver change one counter's bits without a read-modify-write.

The bus accepts one access per cycle and never stalls, so it has no ready signal and no back-pressure. A write is taken on the rising edge where `bus_valid` and `bus_write` are both high. Read data is combinational from `bus_addr`.

Top module: `match_timer4`

## Requirements
- R1: After reset every register, every counter and the prescale count read zero, and `irq` is low.
- R2: Address bits [3:2] select the write effect: 0 plain, 1 OR-in, 2 clear written bits, 3 toggle written bits. This holds for the stored registers: match values (32 bits, at 0x0A0, 0x0B0, 0x0C0, 0x0D0), prescale (32 bits, 0x070), direction (16 bits, 0x020), match control (12 bits, 0x090) and count control (8 bits, 0x180). A read from any alias returns the register.
- R3: Control register 0x010 holds enable bits [3:0] for counters 0..3 and hold bits [7:4] for counters 0..3. While a hold bit is set, that counter and the shared prescale count are cleared on each clock edge and do not advance.
- R4: Direction register 0x020 holds a 4-bit code per counter, with counter i at bits [4i+3:4i]. Code 1 counts down; every other code counts up. Wrap-around from 0xFFFFFFFF to 0, or from 0 to 0xFFFFFFFF, is silent and sets no flag.
- R5: With prescale value P, the prescale count (read-only, 0x080) cycles 0..P while any counter is running. Each running counter steps once every P+1 clocks, so after T running clocks from zero a counter reads T/(P+1) and the prescale count reads T mod (P+1).
- R6: Match control 0x090 gives counter i three bits: 3i flags on match, 3i+1 restarts on match, 3i+2 stops on match. A match is a count step taken while the counter equals its match value.
- R7: Interrupt register 0x000 bits [3:0] are the match flags. A match with the flag bit enabled sets the flag on the edge of that step, so `irq` is seen m+1 clocks after enabling from zero with match value m and no prescaling. `irq` is the OR of the flags. A plain write clears the flags written as 1 and leaves those written as 0. The set and toggle aliases change flags directly.
- R8: A restart on match loads zero instead of stepping, so the counter repeats the sequence 0..m.
- R9: A stop on match clears the counter's enable bit. The counter keeps the match value, or reads zero if restart is also enabled.
- R10: Counters at 0x030, 0x040, 0x050, 0x060 and the prescale count are read-only; writes to them change nothing.
- R11: Count control 0x180 holds a 2-bit code per counter, with counter i at bits [2i+1:2i]. Only code 0 lets the counter step; any other code holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | High for a write when `bus_valid` is high |
| bus_addr | input | 12 | Byte address; bits [11:4] pick the register, bits [3:2] the write alias |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | High while any match flag is set |

## Verification
Most faults in the counters or the prescaler surface as a wrong count value after a known number of running clocks. The bench stops the counters before reading, so such a fault is seen at the first read after the run. A wrong match compare or a wrong flag update shifts the clock on which `irq` rises, and the bench measures that to the exact clock. A wrong alias decode corrupts the next read-back of the register, which the sweep does after every single write.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    WR_PLAIN = 2'd0,
    WR_SET   = 2'd1,
    WR_CLR   = 2'd2,
    WR_TOG   = 2'd3
  } wr_kind_e;

  // Register index = byte address [11:4]
  localparam logic [7:0] RI_FLAG  = 8'h00;
  localparam logic [7:0] RI_CTRL  = 8'h01;
  localparam logic [7:0] RI_DIR   = 8'h02;
  localparam logic [7:0] RI_CNT0  = 8'h03;
  localparam logic [7:0] RI_PRE   = 8'h07;
  localparam logic [7:0] RI_PCNT  = 8'h08;
  localparam logic [7:0] RI_MCTL  = 8'h09;
  localparam logic [7:0] RI_MVAL0 = 8'h0A;
  localparam logic [7:0] RI_MODE  = 8'h18;

  typedef struct packed {
    logic [BUS_W-1:0] set_m;
    logic [BUS_W-1:0] clr_m;
    logic [BUS_W-1:0] tog_m;
  } wr_masks_t;

  // new = ((old & ~clr_m) | set_m) ^ tog_m
  function automatic wr_masks_t make_masks(input logic [BUS_W-1:0] wd, input wr_kind_e k);
    wr_masks_t m;
    m = '0;
    case (k)
      WR_PLAIN: begin m.clr_m = '1; m.set_m = wd; end
      WR_SET:   m.set_m = wd;
      WR_CLR:   m.clr_m = wd;
      default:  m.tog_m = wd;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/mt_prescale.sv
module mt_prescale #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         tick,
  output logic [W-1:0] count
);
  logic [W-1:0] count_q;

  assign tick  = run && !clr && (count_q >= limit);
  assign count = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count_q <= '0;
    else if (clr) count_q <= '0;
    else if (run) count_q <= tick ? '0 : count_q + 1'b1;
  end

  // R5
  pre_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count == '0));
  // R5
  pre_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(count));
  // R3
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/mt_channel.sv
module mt_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         hold,
  input  logic         down,
  input  logic         mode_ok,
  input  logic         tick,
  input  logic [W-1:0] match_val,
  input  logic         act_rst,
  input  logic         act_stop,
  output logic [W-1:0] count,
  output logic         hit
);
  logic [W-1:0] cnt_q;
  logic         step;

  assign step  = enable && !hold && mode_ok && tick;
  assign hit   = step && (cnt_q == match_val);
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (hold)            cnt_q <= '0;
    else if (step) begin
      if (hit && act_rst)      cnt_q <= '0;
      else if (hit && act_stop) cnt_q <= cnt_q;
      else if (down)           cnt_q <= cnt_q - 1'b1;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (count == '0));
  // R8
  ch_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act_rst) |=> (count == '0));
  // R4
  ch_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hit && down) |=> (count == $past(count) - 1'b1));
  // R11
  ch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !hold) |=> $stable(count));
endmodule

// File: rtl/match_timer4.sv
module match_timer4 #(
  parameter int N_CH   = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  import mt_pkg::*;

  localparam int DIR_W  = 4 * N_CH;
  localparam int MCTL_W = 3 * N_CH;
  localparam int MODE_W = 2 * N_CH;

  // register state
  logic [N_CH-1:0]   flag_q, en_q, hold_q;
  logic [DIR_W-1:0]  dir_q;
  logic [MCTL_W-1:0] mctl_q;
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  pre_q;
  logic [CNT_W-1:0]  mval_q [N_CH];

  logic [N_CH-1:0]   flag_n, en_n, hold_n;
  logic [DIR_W-1:0]  dir_n;
  logic [MCTL_W-1:0] mctl_n;
  logic [MODE_W-1:0] mode_n;
  logic [CNT_W-1:0]  pre_n;
  logic [CNT_W-1:0]  mval_n [N_CH];

  // channel side
  logic [CNT_W-1:0]  cnt [N_CH];
  logic [N_CH-1:0]   hit, stop_evt, set_evt, mode_ok, down;
  logic [CNT_W-1:0]  pcnt;
  logic              tick, run, pre_clr;

  // bus decode
  logic       wr_en;
  logic [7:0] ri;
  wr_kind_e   kind;
  wr_masks_t  mk;
  logic [1:0] unused_addr;

  assign wr_en       = bus_valid && bus_write;
  assign ri          = bus_addr[11:4];
  assign kind        = wr_kind_e'(bus_addr[3:2]);
  assign mk          = make_masks(bus_wdata, kind);
  assign unused_addr = bus_addr[1:0];

  // shared prescaler
  assign run     = |(en_q & ~hold_q & mode_ok);
  assign pre_clr = |hold_q;

  mt_prescale #(.W(CNT_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .clr   (pre_clr),
    .limit (pre_q),
    .tick  (tick),
    .count (pcnt)
  );

  // counters
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign mode_ok[i]  = (mode_q[2*i +: 2] == 2'd0);
    assign down[i]     = (dir_q[4*i +: 4] == 4'd1);
    assign set_evt[i]  = hit[i] && mctl_q[3*i];
    assign stop_evt[i] = hit[i] && mctl_q[3*i+2];

    mt_channel #(.W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (en_q[i]),
      .hold      (hold_q[i]),
      .down      (down[i]),
      .mode_ok   (mode_ok[i]),
      .tick      (tick),
      .match_val (mval_q[i]),
      .act_rst   (mctl_q[3*i+1]),
      .act_stop  (mctl_q[3*i+2]),
      .count     (cnt[i]),
      .hit       (hit[i])
    );

    // R9
    stop_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt[i] |=> !en_q[i]);
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> flag_q[i]);
    // R2
    mval_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ri == RI_MVAL0 + 8'(i) && kind == WR_PLAIN)
        |=> (mval_q[i] == $past(bus_wdata[CNT_W-1:0])));
  end

  // next-state of the software-visible registers
  always_comb begin
    en_n   = en_q;
    hold_n = hold_q;
    if (wr_en && ri == RI_CTRL) begin
      en_n   = ((en_q & ~mk.clr_m[N_CH-1:0]) | mk.set_m[N_CH-1:0]) ^ mk.tog_m[N_CH-1:0];
      hold_n = ((hold_q & ~mk.clr_m[4 +: N_CH]) | mk.set_m[4 +: N_CH]) ^ mk.tog_m[4 +: N_CH];
    end
    // a stop from the hardware wins over a write in the same cycle
    en_n = en_n & ~stop_evt;

    flag_n = flag_q;
    if (wr_en && ri == RI_FLAG) begin
      if (kind == WR_PLAIN) flag_n = flag_q & ~bus_wdata[N_CH-1:0];
      else flag_n = ((flag_q & ~mk.clr_m[N_CH-1:0]) | mk.set_m[N_CH-1:0]) ^ mk.tog_m[N_CH-1:0];
    end
    // a match flag wins over a clear in the same cycle
    flag_n = flag_n | set_evt;

    dir_n  = dir_q;
    mctl_n = mctl_q;
    mode_n = mode_q;
    pre_n  = pre_q;
    if (wr_en && ri == RI_DIR)
      dir_n = ((dir_q & ~mk.clr_m[DIR_W-1:0]) | mk.set_m[DIR_W-1:0]) ^ mk.tog_m[DIR_W-1:0];
    if (wr_en && ri == RI_MCTL)
      mctl_n = ((mctl_q & ~mk.clr_m[MCTL_W-1:0]) | mk.set_m[MCTL_W-1:0]) ^ mk.tog_m[MCTL_W-1:0];
    if (wr_en && ri == RI_MODE)
      mode_n = ((mode_q & ~mk.clr_m[MODE_W-1:0]) | mk.set_m[MODE_W-1:0]) ^ mk.tog_m[MODE_W-1:0];
    if (wr_en && ri == RI_PRE)
      pre_n = ((pre_q & ~mk.clr_m[CNT_W-1:0]) | mk.set_m[CNT_W-1:0]) ^ mk.tog_m[CNT_W-1:0];
    for (int i = 0; i < N_CH; i++) begin
      mval_n[i] = mval_q[i];
      if (wr_en && ri == RI_MVAL0 + 8'(i))
        mval_n[i] = ((mval_q[i] & ~mk.clr_m[CNT_W-1:0]) | mk.set_m[CNT_W-1:0]) ^ mk.tog_m[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      hold_q <= '0;
      dir_q  <= '0;
      mctl_q <= '0;
      mode_q <= '0;
      pre_q  <= '0;
      for (int i = 0; i < N_CH; i++) mval_q[i] <= '0;
    end else begin
      flag_q <= flag_n;
      en_q   <= en_n;
      hold_q <= hold_n;
      dir_q  <= dir_n;
      mctl_q <= mctl_n;
      mode_q <= mode_n;
      pre_q  <= pre_n;
      for (int i = 0; i < N_CH; i++) mval_q[i] <= mval_n[i];
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (ri)
      RI_FLAG: bus_rdata = 32'(flag_q);
      RI_CTRL: begin
        bus_rdata[N_CH-1:0] = en_q;
        bus_rdata[4 +: N_CH] = hold_q;
      end
      RI_DIR:  bus_rdata = 32'(dir_q);
      RI_PRE:  bus_rdata = 32'(pre_q);
      RI_PCNT: bus_rdata = 32'(pcnt);
      RI_MCTL: bus_rdata = 32'(mctl_q);
      RI_MODE: bus_rdata = 32'(mode_q);
      default: ;
    endcase
    for (int i = 0; i < N_CH; i++) begin
      if (ri == RI_CNT0 + 8'(i))  bus_rdata = 32'(cnt[i]);
      if (ri == RI_MVAL0 + 8'(i)) bus_rdata = 32'(mval_q[i]);
    end
  end

  assign irq = |flag_q;
endmodule

// File: tb/match_timer4_tb.sv
module match_timer4_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [11:0] A_FLAG = 12'h000, A_CTRL = 12'h010, A_DIR = 12'h020,
                          A_PRE = 12'h070, A_PCNT = 12'h080, A_MCTL = 12'h090,
                          A_MODE = 12'h180;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  match_timer4 u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [11:0] a_cnt(input int c);
    return 12'h030 + 12'(c * 16);
  endfunction
  function automatic logic [11:0] a_mval(input int c);
    return 12'h0A0 + 12'(c * 16);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, taken on the next rising edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input int c);
    wr(A_CTRL, 32'(1) << (4 + c));
    wr(A_CTRL, 32'h0);
  endtask

  function automatic logic [31:0] model_wr(input logic [31:0] old, input logic [31:0] d, input int k);
    case (k)
      0: return d;
      1: return old | d;
      2: return old & ~d;
      default: return old ^ d;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [11:0] ra [15];
    logic [11:0] sw_a [8];
    logic [31:0] sw_m [8];
    ra = '{12'h000, 12'h010, 12'h020, 12'h030, 12'h040, 12'h050, 12'h060, 12'h070,
           12'h080, 12'h090, 12'h0A0, 12'h0B0, 12'h0C0, 12'h0D0, 12'h180};
    sw_a = '{12'h0A0, 12'h0B0, 12'h0C0, 12'h0D0, 12'h070, 12'h020, 12'h090, 12'h180};
    sw_m = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
             32'h0000FFFF, 32'h00000FFF, 32'h000000FF};

    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    for (int i = 0; i < 15; i++) begin
      rd(ra[i], v);
      chk("R1 reset value", v, 32'h0);
    end
    chk("R1 irq low", 32'(irq), 32'h0);

    // R2: alias sweep, read back through a different alias each time
    for (int r = 0; r < 8; r++) begin
      logic [31:0] m;
      m = '0;
      for (int p = 0; p < 4; p++) begin
        for (int k = 0; k < 4; k++) begin
          logic [31:0] pat;
          pat = (32'h9E3779B9 * 32'(p + r + 1)) ^ (32'(k) << (p * 7));
          wr(sw_a[r] + 12'(k * 4), pat);
          m = model_wr(m, pat, k) & sw_m[r];
          rd(sw_a[r] + 12'(((k + 1) % 4) * 4), v);
          chk("R2 alias write", v, m);
        end
      end
      wr(sw_a[r], 32'h0);
    end

    // R5: prescale sweep
    for (int p = 0; p < 4; p++) begin
      wr(A_PRE, 32'(p));
      for (int kk = 0; kk < 2; kk++) begin
        int k;
        int t;
        k = 3 + 4 * kk;
        t = k + 1;
        restart(0);
        wr(A_CTRL, 32'h1);
        idle(k);
        wr(A_CTRL, 32'h0);
        rd(a_cnt(0), v);
        chk("R5 counter after prescaled run", v, 32'(t / (p + 1)));
        rd(A_PCNT, v);
        chk("R5 prescale count", v, 32'(t % (p + 1)));
      end
    end

    // R3: hold bit with enable set keeps counter and prescale count at zero
    wr(A_PRE, 32'h3);
    wr(A_CTRL, 32'h11);
    idle(6);
    rd(a_cnt(0), v);
    chk("R3 held counter", v, 32'h0);
    rd(A_PCNT, v);
    chk("R3 held prescale count", v, 32'h0);
    wr(A_CTRL, 32'h0);
    wr(A_PRE, 32'h0);

    // R4: down count with wrap, then up across the top, no flag
    wr(A_DIR, 32'h10);
    wr(A_MCTL, 32'(1) << 3);
    wr(a_mval(1), 32'd5);
    restart(1);
    wr(A_CTRL, 32'h2);
    idle(2);
    wr(A_CTRL, 32'h0);
    rd(a_cnt(1), v);
    chk("R4 down wrap", v, 32'hFFFFFFFD);
    chk("R4 no flag on wrap", 32'(irq), 32'h0);
    wr(A_DIR, 32'h0);
    wr(A_CTRL, 32'h2);
    idle(3);
    wr(A_CTRL, 32'h0);
    rd(a_cnt(1), v);
    chk("R4 up wrap", v, 32'h1);
    chk("R4 no flag on wrap up", 32'(irq), 32'h0);
    wr(A_MCTL, 32'h0);

    // R10: read-only counters ignore writes
    wr(a_cnt(1), 32'h1234ABCD);
    rd(a_cnt(1), v);
    chk("R10 counter write ignored", v, 32'h1);
    wr(A_PCNT, 32'h7);
    rd(A_PCNT, v);
    chk("R10 prescale count write ignored", v, 32'h0);

    // R4: code other than 1 counts up
    wr(A_DIR, 32'h200);
    restart(2);
    wr(A_CTRL, 32'h4);
    idle(4);
    wr(A_CTRL, 32'h0);
    rd(a_cnt(2), v);
    chk("R4 code 2 counts up", v, 32'd5);
    wr(A_DIR, 32'h0);

    // R6 R7: flag timing sweep per channel
    for (int c = 0; c < 4; c++) begin
      for (int mi = 0; mi < 2; mi++) begin
        int m;
        int n;
        m = 1 + 3 * mi;
        wr(A_MCTL, 32'(1) << (3 * c));
        wr(a_mval(c), 32'(m));
        restart(c);
        wr(A_CTRL, 32'(1) << c);
        n = 0;
        while (irq !== 1'b1 && n < 40) begin
          idle(1);
          n++;
        end
        chk("R7 clocks to irq", 32'(n), 32'(m + 1));
        wr(A_CTRL, 32'h0);
        rd(A_FLAG, v);
        chk("R6 flag of matching channel", v, 32'(1) << c);
        wr(A_FLAG, 32'h0);
        rd(A_FLAG, v);
        chk("R7 plain write of 0 keeps flag", v, 32'(1) << c);
        wr(A_FLAG, 32'(1) << c);
        chk("R7 plain write of 1 clears", 32'(irq), 32'h0);
      end
    end
    wr(A_MCTL, 32'h0);

    // R7: set and toggle aliases on the flags
    wr(A_FLAG + 12'h4, 32'h5);
    rd(A_FLAG, v);
    chk("R7 set alias", v, 32'h5);
    chk("R7 irq from set flag", 32'(irq), 32'h1);
    wr(A_FLAG + 12'hC, 32'h5);
    chk("R7 toggle alias clears", 32'(irq), 32'h0);

    // R8: restart on match gives period m+1
    wr(A_MCTL, 32'(1) << 7);
    wr(a_mval(2), 32'd3);
    restart(2);
    wr(A_CTRL, 32'h4);
    idle(9);
    wr(A_CTRL, 32'h0);
    rd(a_cnt(2), v);
    chk("R8 restart period", v, 32'(10 % 4));

    // R9: stop on match
    wr(A_MCTL, 32'(1) << 11);
    wr(a_mval(3), 32'd6);
    restart(3);
    wr(A_CTRL, 32'h8);
    idle(20);
    rd(A_CTRL, v);
    chk("R9 enable cleared", v, 32'h0);
    rd(a_cnt(3), v);
    chk("R9 counter keeps match", v, 32'd6);
    wr(A_MCTL, (32'(1) << 11) | (32'(1) << 10));
    restart(3);
    wr(A_CTRL, 32'h8);
    idle(20);
    rd(A_CTRL, v);
    chk("R9 one-shot enable cleared", v, 32'h0);
    rd(a_cnt(3), v);
    chk("R9 one-shot counter zero", v, 32'h0);
    wr(A_MCTL, 32'h0);

    // R11: count-control code 1 holds the counter
    wr(A_MODE, 32'h40);
    rd(A_MODE, v);
    chk("R11 mode readback", v, 32'h40);
    restart(3);
    wr(A_CTRL, 32'h8);
    idle(5);
    wr(A_CTRL, 32'h0);
    rd(a_cnt(3), v);
    chk("R11 non-timer code holds", v, 32'h0);
    wr(A_MODE, 32'h0);
    wr(A_CTRL, 32'h8);
    idle(5);
    wr(A_CTRL, 32'h0);
    rd(a_cnt(3), v);
    chk("R11 timer code counts", v, 32'd6);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule